// File: doc/BRIEF.md
# Control-Flow Next-PC Unit

This block decides where execution goes after each control-flow instruction of a 32-bit core. It is given the instruction word and the values of the two source registers it names. From these it works out the following program counter and whether the instruction redirects the flow. It also produces the return-address write that call instructions need.

The program counter and a three-bit interrupt-enable register are held inside the block. When `step_i` is high the PC loads the computed next address. A return through the exception-address or breakpoint-address register copies the matching saved enable bit into the live enable bit. Other logic can overwrite the enable register through a write port. Fetch, flushing and exception entry belong to other blocks.

Top module: `ctrl_flow_unit`

## Requirements
- R1: After reset `pc_o` equals the parameter `RESET_PC` (default 0) and `ie_o` is zero.
- R2: Opcode is instruction bits 31:26. Conditional branches are 0x11 (equal), 0x12 (signed greater), 0x13 (signed greater-or-equal), 0x14 (unsigned greater-or-equal), 0x15 (unsigned greater) and 0x17 (not equal). Each compares `rs_a_i` against `rs_b_i`. When the condition holds, `taken_o` is 1 and `next_pc_o` is PC plus bits 15:0 sign-extended and multiplied by 4. Otherwise `taken_o` is 0 and `next_pc_o` is PC+4.
- R3: The signed conditions treat the operands as two's complement values. The unsigned conditions treat them as magnitudes, so 0xFFFFFFFF compared with 1 gives opposite answers under the two kinds.
- R4: Opcodes 0x38 (jump) and 0x3E (call) always redirect to PC plus bits 25:0 sign-extended and multiplied by 4.
- R5: Opcodes 0x36 and 0x3E assert `link_we_o`, with `link_idx_o` = 29 and `link_data_o` = PC+4. No other opcode asserts `link_we_o`.
- R6: Opcodes 0x30 (register jump) and 0x36 (register call) redirect to the value of `rs_a_i`, the register named in bits 25:21. `next_pc_o` always has bits 1:0 cleared.
- R7: A stepped 0x30 whose bits 25:21 equal 30 sets IE (bit 0) to the saved EIE bit (bit 1) and leaves bits 2:1 unchanged.
- R8: A stepped 0x30 whose bits 25:21 equal 31 sets IE (bit 0) to the saved BIE bit (bit 2) and leaves bits 2:1 unchanged.
- R9: A 0x30 through any other register leaves the enable register unchanged.
- R10: The enable register layout is bit 0 IE, bit 1 EIE, bit 2 BIE. Bits 31:3 of `ie_o` always read zero. `ie_we_i` loads bits 2:0 of `ie_wdata_i` on the next edge and takes priority over a return in the same cycle.
- R11: Any other opcode (for example 0x16 or 0x0D) gives `taken_o` = 0 and `next_pc_o` = PC+4.
- R12: `pc_o` loads `next_pc_o` on an edge where `step_i` is high and holds otherwise. Without `step_i`, returns do not change the enable register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | The presented instruction executes on this edge |
| instr_i | input | 32 | Instruction word |
| rs_a_i | input | 32 | Value of register named by bits 25:21 |
| rs_b_i | input | 32 | Value of register named by bits 20:16 |
| ie_we_i | input | 1 | Enable-register write strobe |
| ie_wdata_i | input | 32 | Enable-register write data (bits 2:0 used) |
| pc_o | output | 32 | Current program counter |
| next_pc_o | output | 32 | Computed next program counter |
| taken_o | output | 1 | Instruction redirects the flow |
| link_we_o | output | 1 | Return-address write strobe |
| link_idx_o | output | 5 | Return-address register index |
| link_data_o | output | 32 | Return address (PC+4) |
| ie_o | output | 32 | Interrupt-enable register |

## Verification
Some properties are checked by assertions on every cycle:
- the PC follows the computed next address on a step and holds without one;
- a link write only comes with a redirect;
- a flow that is not taken always advances by four;
- the enable register's upper bits stay zero;
- the IE bit is restored correctly on exception and breakpoint returns.

Other behaviour can only be shown by the bench's directed scenarios:
- the exact target arithmetic of each condition, including negative offsets and the signed-versus-unsigned split;
- the clearing of a misaligned register target;
- the write-over-return priority.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_JREG  = 6'h30;
  localparam logic [5:0] OP_CALLR = 6'h36;
  localparam logic [5:0] OP_JIMM  = 6'h38;
  localparam logic [5:0] OP_CALLI = 6'h3E;

  typedef enum logic [2:0] {
    K_NONE, K_COND, K_JREG, K_CALLR, K_JIMM, K_CALLI
  } flow_kind_e;

  // 16-bit word offset, sign-extended, scaled to bytes
  function automatic logic [XLEN-1:0] offset_short(input logic [15:0] imm);
    return {{(XLEN-18){imm[15]}}, imm, 2'b00};
  endfunction

  // 26-bit word offset, sign-extended, scaled to bytes
  function automatic logic [XLEN-1:0] offset_long(input logic [25:0] imm);
    return {{(XLEN-28){imm[25]}}, imm, 2'b00};
  endfunction

  // low opcode bits select the comparison
  function automatic logic compare_hit(input logic [2:0] sel,
                                       input logic [XLEN-1:0] a,
                                       input logic [XLEN-1:0] b);
    case (sel)
      3'd1:    return a == b;
      3'd2:    return $signed(a) >  $signed(b);
      3'd3:    return $signed(a) >= $signed(b);
      3'd4:    return a >= b;
      3'd5:    return a >  b;
      3'd7:    return a != b;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cfu_decode.sv
module cfu_decode
  import cfu_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output flow_kind_e      kind,
  output logic [2:0]      cond_sel,
  output logic [4:0]      src_idx
);
  logic [5:0] opcode;
  assign opcode   = instr[31:26];
  assign cond_sel = opcode[2:0];
  assign src_idx  = instr[25:21];

  always_comb begin
    kind = K_NONE;
    if (opcode[5:3] == 3'b010 && opcode[2:0] != 3'd0 && opcode[2:0] != 3'd6)
      kind = K_COND;
    else if (opcode == OP_JREG)  kind = K_JREG;
    else if (opcode == OP_CALLR) kind = K_CALLR;
    else if (opcode == OP_JIMM)  kind = K_JIMM;
    else if (opcode == OP_CALLI) kind = K_CALLI;
  end
endmodule

// File: rtl/cfu_cmp.sv
module cfu_cmp
  import cfu_pkg::*;
(
  input  logic [2:0]      cond_sel,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            hit
);
  assign hit = compare_hit(cond_sel, opa, opb);
endmodule

// File: rtl/cfu_target.sv
module cfu_target
  import cfu_pkg::*;
(
  input  flow_kind_e      kind,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] reg_target,
  input  logic            cond_hit,
  output logic [XLEN-1:0] next_pc,
  output logic            taken
);
  logic [XLEN-1:0] seq_pc, raw_pc;
  assign seq_pc = pc + XLEN'(4);

  always_comb begin
    raw_pc = seq_pc;
    taken  = 1'b0;
    case (kind)
      K_COND: if (cond_hit) begin
        raw_pc = pc + offset_short(instr[15:0]);
        taken  = 1'b1;
      end
      K_JREG, K_CALLR: begin
        raw_pc = reg_target;
        taken  = 1'b1;
      end
      K_JIMM, K_CALLI: begin
        raw_pc = pc + offset_long(instr[25:0]);
        taken  = 1'b1;
      end
      default: ;
    endcase
  end

  assign next_pc = {raw_pc[XLEN-1:2], 2'b00};
endmodule

// File: rtl/cfu_iereg.sv
module cfu_iereg
  import cfu_pkg::*;
#(
  parameter int IE_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            ret_exc,
  input  logic            ret_brk,
  input  logic            we,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] ie
);
  logic [IE_W-1:0] ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ie_q <= '0;
    else if (we)                 ie_q <= wdata[IE_W-1:0];
    else if (step && ret_exc)    ie_q[0] <= ie_q[1];
    else if (step && ret_brk)    ie_q[0] <= ie_q[2];
  end

  assign ie = {{(XLEN-IE_W){1'b0}}, ie_q};
endmodule

// File: rtl/ctrl_flow_unit.sv
module ctrl_flow_unit
  import cfu_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0,
  parameter logic [4:0]  LINK_IDX = 5'd29,
  parameter logic [4:0]  EXC_IDX  = 5'd30,
  parameter logic [4:0]  BRK_IDX  = 5'd31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step_i,
  input  logic [31:0] instr_i,
  input  logic [31:0] rs_a_i,
  input  logic [31:0] rs_b_i,
  input  logic        ie_we_i,
  input  logic [31:0] ie_wdata_i,
  output logic [31:0] pc_o,
  output logic [31:0] next_pc_o,
  output logic        taken_o,
  output logic        link_we_o,
  output logic [4:0]  link_idx_o,
  output logic [31:0] link_data_o,
  output logic [31:0] ie_o
);
  flow_kind_e kind;
  logic [2:0] cond_sel;
  logic [4:0] src_idx;
  logic       cond_hit;
  logic       ret_exc, ret_brk, is_link;
  logic [31:0] pc_q;

  cfu_decode u_dec (.instr(instr_i), .kind(kind), .cond_sel(cond_sel), .src_idx(src_idx));

  cfu_cmp u_cmp (.cond_sel(cond_sel), .opa(rs_a_i), .opb(rs_b_i), .hit(cond_hit));

  cfu_target u_tgt (
    .kind(kind), .pc(pc_q), .instr(instr_i), .reg_target(rs_a_i),
    .cond_hit(cond_hit), .next_pc(next_pc_o), .taken(taken_o)
  );

  assign ret_exc = (kind == K_JREG) && (src_idx == EXC_IDX);
  assign ret_brk = (kind == K_JREG) && (src_idx == BRK_IDX);
  assign is_link = (kind == K_CALLR) || (kind == K_CALLI);

  cfu_iereg #(.IE_W(3)) u_ie (
    .clk(clk), .rst_n(rst_n), .step(step_i), .ret_exc(ret_exc),
    .ret_brk(ret_brk), .we(ie_we_i), .wdata(ie_wdata_i), .ie(ie_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_q <= RESET_PC;
    else if (step_i) pc_q <= next_pc_o;
  end

  assign pc_o        = pc_q;
  assign link_we_o   = is_link;
  assign link_idx_o  = LINK_IDX;
  assign link_data_o = pc_q + 32'd4;
endmodule

// File: rtl/cfu_checker.sv
module cfu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        step_i,
  input logic        ie_we_i,
  input logic [31:0] pc_o,
  input logic [31:0] next_pc_o,
  input logic        taken_o,
  input logic        link_we_o,
  input logic [31:0] ie_o,
  input logic        ret_exc,
  input logic        ret_brk
);
  assert_pc_follow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> pc_o == $past(next_pc_o));

  assert_pc_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(pc_o));

  assert_link_redirect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_o |-> taken_o);

  assert_fallthrough_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !taken_o |-> next_pc_o == pc_o + 32'd4);

  assert_pc_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_o[1:0] == 2'b00);

  assert_ie_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ie_o[31:3] == '0);

  assert_exc_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && ret_exc && !ie_we_i) |=>
      (ie_o[0] == $past(ie_o[1])) && (ie_o[2:1] == $past(ie_o[2:1])));

  assert_brk_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && ret_brk && !ie_we_i) |=>
      (ie_o[0] == $past(ie_o[2])) && (ie_o[2:1] == $past(ie_o[2:1])));
endmodule

bind ctrl_flow_unit cfu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .step_i(step_i), .ie_we_i(ie_we_i),
  .pc_o(pc_o), .next_pc_o(next_pc_o), .taken_o(taken_o),
  .link_we_o(link_we_o), .ie_o(ie_o), .ret_exc(ret_exc), .ret_brk(ret_brk)
);

// File: tb/sim_ctrl_flow_unit.sv
`timescale 1ns/1ps
module sim_ctrl_flow_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_i = 1'b0;
  logic [31:0] instr_i = '0, rs_a_i = '0, rs_b_i = '0;
  logic        ie_we_i = 1'b0;
  logic [31:0] ie_wdata_i = '0;
  logic [31:0] pc_o, next_pc_o, link_data_o, ie_o;
  logic        taken_o, link_we_o;
  logic [4:0]  link_idx_o;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_pc = 32'h0;

  always #5 clk = ~clk;

  ctrl_flow_unit u0 (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .instr_i(instr_i),
    .rs_a_i(rs_a_i), .rs_b_i(rs_b_i), .ie_we_i(ie_we_i), .ie_wdata_i(ie_wdata_i),
    .pc_o(pc_o), .next_pc_o(next_pc_o), .taken_o(taken_o), .link_we_o(link_we_o),
    .link_idx_o(link_idx_o), .link_data_o(link_data_o), .ie_o(ie_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] ra,
                                      input logic [4:0] rb, input logic [15:0] imm);
    return {op, ra, rb, imm};
  endfunction

  function automatic logic [31:0] encj(input logic [5:0] op, input logic [25:0] imm);
    return {op, imm};
  endfunction

  // present one instruction, check the combinational view, clock it, check the PC
  task automatic exec(input string req, input logic [31:0] ins, input logic [31:0] a,
                      input logic [31:0] b, input logic [31:0] exp_next,
                      input logic exp_taken, input logic exp_link);
    @(negedge clk);
    instr_i = ins; rs_a_i = a; rs_b_i = b; step_i = 1'b1;
    #1;
    check({req, " next"}, next_pc_o, exp_next);
    check({req, " taken"}, {31'b0, taken_o}, {31'b0, exp_taken});
    check({req, " link_we"}, {31'b0, link_we_o}, {31'b0, exp_link});
    if (exp_link) begin
      check({req, " link_idx"}, {27'b0, link_idx_o}, 32'd29);
      check({req, " link_data"}, link_data_o, exp_pc + 32'd4);
    end
    @(posedge clk); #1;
    step_i = 1'b0;
    check({req, " pc"}, pc_o, exp_next);
    exp_pc = exp_next;
  endtask

  task automatic ie_write(input logic [31:0] v);
    @(negedge clk);
    ie_we_i = 1'b1; ie_wdata_i = v;
    @(posedge clk); #1;
    ie_we_i = 1'b0;
    check("R10 ie write", ie_o, {29'b0, v[2:0]});
  endtask

  task automatic t_reset;
    check("R1 reset pc", pc_o, 32'h0);
    check("R1 reset ie", ie_o, 32'h0);
  endtask

  task automatic t_cond;
    exec("R6 seed", enc(6'h30, 5'd3, 5'd0, 16'h0), 32'h100, 0, 32'h100, 1'b1, 1'b0);
    exec("R2 eq taken", enc(6'h11, 1, 2, 16'd5), 32'd7, 32'd7, exp_pc + 32'd20, 1'b1, 1'b0);
    exec("R2 eq not", enc(6'h11, 1, 2, 16'd5), 32'd7, 32'd8, exp_pc + 32'd4, 1'b0, 1'b0);
    exec("R2 ne back", enc(6'h17, 1, 2, 16'hFFFE), 32'd1, 32'd2, exp_pc - 32'd8, 1'b1, 1'b0);
    exec("R2 ge equal", enc(6'h13, 1, 2, 16'd3), 32'd9, 32'd9, exp_pc + 32'd12, 1'b1, 1'b0);
  endtask

  task automatic t_signed;
    exec("R3 sgt neg", enc(6'h12, 1, 2, 16'd4), 32'hFFFFFFFF, 32'd1, exp_pc + 32'd4, 1'b0, 1'b0);
    exec("R3 ugt big", enc(6'h15, 1, 2, 16'd4), 32'hFFFFFFFF, 32'd1, exp_pc + 32'd16, 1'b1, 1'b0);
    exec("R3 uge small", enc(6'h14, 1, 2, 16'd4), 32'd1, 32'hFFFFFFFF, exp_pc + 32'd4, 1'b0, 1'b0);
    exec("R3 sge pos", enc(6'h13, 1, 2, 16'd2), 32'd1, 32'hFFFFFFFF, exp_pc + 32'd8, 1'b1, 1'b0);
  endtask

  task automatic t_long;
    exec("R4 jump back", encj(6'h38, 26'h3FFFFFF), 0, 0, exp_pc - 32'd4, 1'b1, 1'b0);
    exec("R4 R5 calli", encj(6'h3E, 26'h10), 0, 0, exp_pc + 32'd64, 1'b1, 1'b1);
  endtask

  task automatic t_reg;
    exec("R6 R5 call misaligned", enc(6'h36, 5'd7, 0, 0), 32'h2003, 0, 32'h2000, 1'b1, 1'b1);
    exec("R6 jump", enc(6'h30, 5'd4, 0, 0), 32'h3006, 0, 32'h3004, 1'b1, 1'b0);
  endtask

  task automatic t_other;
    exec("R11 op16", enc(6'h16, 1, 2, 16'h40), 32'd5, 32'd5, exp_pc + 32'd4, 1'b0, 1'b0);
    exec("R11 op0d", enc(6'h0D, 1, 2, 16'h40), 0, 0, exp_pc + 32'd4, 1'b0, 1'b0);
  endtask

  task automatic t_returns;
    ie_write(32'hFFFF_FFFA);  // upper bits dropped, IE=0 EIE=1
    check("R10 upper zero", ie_o, 32'h2);
    exec("R7 exc ret", enc(6'h30, 5'd30, 0, 0), 32'h400, 0, 32'h400, 1'b1, 1'b0);
    check("R7 ie set", ie_o, 32'h3);
    ie_write(32'h1);
    exec("R7 exc ret clr", enc(6'h30, 5'd30, 0, 0), 32'h404, 0, 32'h404, 1'b1, 1'b0);
    check("R7 ie clr", ie_o, 32'h0);
    ie_write(32'h4);
    exec("R8 brk ret", enc(6'h30, 5'd31, 0, 0), 32'h500, 0, 32'h500, 1'b1, 1'b0);
    check("R8 ie set", ie_o, 32'h5);
    ie_write(32'h3);
    exec("R8 brk ret clr", enc(6'h30, 5'd31, 0, 0), 32'h504, 0, 32'h504, 1'b1, 1'b0);
    check("R8 ie clr", ie_o, 32'h2);
    exec("R9 plain jump", enc(6'h30, 5'd5, 0, 0), 32'h600, 0, 32'h600, 1'b1, 1'b0);
    check("R9 ie kept", ie_o, 32'h2);
  endtask

  task automatic t_priority;
    @(negedge clk);
    instr_i = enc(6'h30, 5'd30, 0, 0); rs_a_i = 32'h700; step_i = 1'b1;
    ie_we_i = 1'b1; ie_wdata_i = 32'h4;
    @(posedge clk); #1;
    step_i = 1'b0; ie_we_i = 1'b0;
    exp_pc = 32'h700;
    check("R10 write wins", ie_o, 32'h4);
  endtask

  task automatic t_hold;
    ie_write(32'h2);
    @(negedge clk);
    instr_i = enc(6'h30, 5'd30, 0, 0); rs_a_i = 32'h900; step_i = 1'b0;
    @(posedge clk); #1;
    check("R12 pc hold", pc_o, exp_pc);
    check("R12 ie hold", ie_o, 32'h2);
  endtask

  initial begin
    fork
      begin
        #(10 * 20000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
      begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        t_reset();
        t_cond();
        t_signed();
        t_long();
        t_reg();
        t_other();
        t_returns();
        t_priority();
        t_hold();
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule